// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the status and control word for a single downstream port of a host controller. Software reads the whole 32-bit word and writes it through a plain register interface (`wr_en`, `wr_data`, `rd_data`). The link-training logic, the port PHY and the power switch sit on the other side. They report connection, over-current, link-state updates, reset completion, cold attach and link configuration errors through single-cycle or level inputs. The block drives the requested port reset, the warm-reset qualifier, the current link state, port power and the indicator colour back to them.

Seven sticky change flags record hardware events until software clears them by writing ones. `irq` stays high while any of them is set. Software can change the link-state field only when it also sets a strobe bit in the same write. A port reset writes the speed field when it completes, and a warm reset also clears the cold-attach status when it completes. The register interface has no back-pressure: every write with `wr_en` high takes effect at that clock edge, and `rd_data` always shows the current state.

Top module: `psc_port_reg`

## Requirements
- R1: A synchronous active-high `rst` makes `rd_data` read 0x0000_0200: every field is zero except port power (bit 9), which is one. `irq` is low and `power_out` is high.
- R2: Bit 0 (connected) and bit 3 (over-current) show the `hw_connect` and `hw_overcur` levels sampled at the last clock edge. A change in either level sets bit 17 or bit 20 respectively at that same edge. Software writes to bits 0, 3 and 13:10 have no effect.
- R3: A software write replaces link state bits 8:5 only when the same write has bit 16 set. Bit 16 itself always reads 0.
- R4: A cycle with `hw_ls_valid` high and `hw_ls` different from the current state loads `hw_ls` into bits 8:5. `hw_ls_valid` takes priority over a software strobe write in the same cycle. The encodings are U0=0, U1=1, U2=2, U3=3, Disabled=4, RxDetect=5, Inactive=6, Polling=7, Recovery=8, HotReset=9, Compliance=10, Test=11 and Resume=15. Only the following hardware-driven changes set the link-change flag (bit 22):
  - U3 to Resume;
  - Resume to U0;
  - Recovery to U0, when the state before Recovery was Resume or U3;
  - U3 to U0;
  - U2 to U0;
  - U0 to Disabled;
  - any state to Inactive.
- R5: Writing 1 to bit 4 while no reset is in progress sets bit 4 and clears enabled (bit 1). A `hw_reset_done` pulse while bit 4 is set clears bit 4, sets the reset-change flag (bit 21) and sets enabled to the `hw_connect` level.
- R6: Speed bits 13:10 read 0 until a port reset completes. At completion, if `hw_connect` is high, they take `hw_speed` (1 full, 2 low, 3 high, 4 SuperSpeed, 5 SuperSpeedPlus). They return to 0 when the connection drops outside a completion cycle.
- R7: Writing 1 to bit 31 starts a reset marked as warm, and `warm_reset_out` is high while that reset runs. Its completion sets the warm-reset change flag (bit 19) and clears cold-attach status (bit 24), unless `hw_cold_attach` pulses in the same cycle. A `hw_cold_attach` pulse sets bit 24. Bit 31 reads 0.
- R8: Writing 1 to bit 1 clears enabled without setting the enable-change flag (bit 18). A disconnect or a rising over-current while enabled clears enabled and sets bit 18, unless a reset starts or completes in that cycle. Writing 0 to bit 1 never enables the port.
- R9: A `hw_cfg_err` pulse sets the configuration-error change flag (bit 23).
- R10: Change flags in bits 23:17 clear only when software writes 1 to them. Writing 0 leaves them alone. A hardware set in the same cycle as a software clear leaves the flag set.
- R11: `irq` is high exactly when at least one of bits 23:17 is set.
- R12: Bits 9 (power) and 15:14 (indicator) take the written value on every write and drive `power_out` and `indicator_out`. Bit 2, bits 30:25 and bit 16 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| hw_connect | input | 1 | Device-present level |
| hw_overcur | input | 1 | Over-current level |
| hw_ls_valid | input | 1 | Link-state report valid |
| hw_ls | input | 4 | Reported link state |
| hw_speed | input | 4 | Negotiated speed code at reset completion |
| hw_reset_done | input | 1 | Port reset completion pulse |
| hw_cfg_err | input | 1 | Link configuration error pulse |
| hw_cold_attach | input | 1 | Cold attach detected pulse |
| port_reset_out | output | 1 | Port reset in progress |
| warm_reset_out | output | 1 | Running reset is warm |
| link_state_out | output | 4 | Current link state field |
| power_out | output | 1 | Port power enable |
| indicator_out | output | 2 | Port indicator colour |
| irq | output | 1 | Port change interrupt request |

## Verification
The bench aims at the Recovery-to-U0 transition, whose flag depends on the state two steps back. A design that remembered only one step would raise the flag after Polling or miss it after Resume. It pits a software clear against a hardware set in the same cycle, where a design with the wrong priority loses the event. It writes link-state values without the strobe, where a careless decode moves the link. It also runs long random mixes of resets, warm resets, disconnects and over-current. These catch a speed field that stays stale after a disconnect, an enable-change flag raised by a software disable, and cold-attach status that survives a completed warm reset.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int REG_W  = 32;
  localparam int LS_W   = 4;
  localparam int SPD_W  = 4;
  localparam int N_CHG  = 7;

  // field positions
  localparam int B_CONN   = 0;
  localparam int B_EN     = 1;
  localparam int B_OC     = 3;
  localparam int B_PRST   = 4;
  localparam int B_LS_LO  = 5;
  localparam int B_PWR    = 9;
  localparam int B_SPD_LO = 10;
  localparam int B_IND_LO = 14;
  localparam int B_STROBE = 16;
  localparam int B_CHG_LO = 17;
  localparam int B_CAS    = 24;
  localparam int B_WARM   = 31;

  // change flag order inside the flag vector
  localparam int C_CSC = 0;
  localparam int C_PEC = 1;
  localparam int C_WRC = 2;
  localparam int C_OCC = 3;
  localparam int C_RC  = 4;
  localparam int C_PLC = 5;
  localparam int C_CEC = 6;

  typedef enum logic [LS_W-1:0] {
    LS_U0       = 4'd0,
    LS_U1       = 4'd1,
    LS_U2       = 4'd2,
    LS_U3       = 4'd3,
    LS_DISABLED = 4'd4,
    LS_RXDET    = 4'd5,
    LS_INACTIVE = 4'd6,
    LS_POLLING  = 4'd7,
    LS_RECOVERY = 4'd8,
    LS_HOTRST   = 4'd9,
    LS_COMPLY   = 4'd10,
    LS_TEST     = 4'd11,
    LS_RESUME   = 4'd15
  } link_e;
endpackage

// File: rtl/psc_change_flags.sv
module psc_change_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (set_i[g])
        flag_q[g] <= 1'b1;          // hardware set beats software clear
      else if (clr_i[g])
        flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/psc_link_track.sv
module psc_link_track
  import psc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_valid,
  input  logic [LS_W-1:0] hw_ls,
  input  logic            sw_wr,
  input  logic [LS_W-1:0] sw_ls,
  output logic [LS_W-1:0] ls_q,
  output logic            plc_set
);
  logic [LS_W-1:0] prev_q;
  logic            hw_chg, sw_chg;

  function automatic logic flag_worthy(input logic [LS_W-1:0] pp,
                                       input logic [LS_W-1:0] o,
                                       input logic [LS_W-1:0] n);
    logic r;
    r = 1'b0;
    if (n == LS_INACTIVE) r = 1'b1;
    if (o == LS_U3 && n == LS_RESUME) r = 1'b1;
    if (o == LS_RESUME && n == LS_U0) r = 1'b1;
    if (o == LS_RECOVERY && n == LS_U0 &&
        (pp == LS_RESUME || pp == LS_U3)) r = 1'b1;
    if (o == LS_U3 && n == LS_U0) r = 1'b1;
    if (o == LS_U2 && n == LS_U0) r = 1'b1;
    if (o == LS_U0 && n == LS_DISABLED) r = 1'b1;
    return r;
  endfunction

  assign hw_chg  = hw_valid && (hw_ls != ls_q);
  assign sw_chg  = !hw_valid && sw_wr && (sw_ls != ls_q);
  assign plc_set = hw_chg && flag_worthy(prev_q, ls_q, hw_ls);

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q   <= '0;
      prev_q <= '0;
    end else if (hw_chg) begin
      prev_q <= ls_q;
      ls_q   <= hw_ls;
    end else if (sw_chg) begin
      prev_q <= ls_q;
      ls_q   <= sw_ls;
    end
  end
endmodule

// File: rtl/psc_reset_ctl.sv
module psc_reset_ctl
  import psc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             conn_q,
  input  logic             conn_in,
  input  logic             oc_q,
  input  logic             oc_in,
  input  logic             start,
  input  logic             start_warm,
  input  logic             sw_disable,
  input  logic             done,
  input  logic [SPD_W-1:0] speed_in,
  input  logic             cold_attach,
  output logic             prst_q,
  output logic             warm_q,
  output logic             en_q,
  output logic [SPD_W-1:0] speed_q,
  output logic             cas_q,
  output logic             rc_set,
  output logic             wrc_set,
  output logic             pec_set
);
  logic complete, begin_rst, drop, unplug;

  assign complete  = done && prst_q;
  assign begin_rst = !complete && start && !prst_q;
  assign unplug    = conn_q && !conn_in;
  assign drop      = en_q && (unplug || (!oc_q && oc_in));
  assign pec_set   = drop && !complete && !begin_rst;
  assign rc_set    = complete;
  assign wrc_set   = complete && warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prst_q  <= 1'b0;
      warm_q  <= 1'b0;
      en_q    <= 1'b0;
      speed_q <= '0;
    end else if (complete) begin
      prst_q  <= 1'b0;
      warm_q  <= 1'b0;
      en_q    <= conn_in;
      speed_q <= conn_in ? speed_in : '0;
    end else begin
      if (begin_rst) begin
        prst_q <= 1'b1;
        warm_q <= start_warm;
        en_q   <= 1'b0;
      end else if (drop || sw_disable) begin
        en_q   <= 1'b0;
      end
      if (unplug) speed_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cas_q <= 1'b0;
    else if (cold_attach)
      cas_q <= 1'b1;
    else if (complete && warm_q)
      cas_q <= 1'b0;
  end
endmodule

// File: rtl/psc_port_reg.sv
module psc_port_reg
  import psc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             hw_connect,
  input  logic             hw_overcur,
  input  logic             hw_ls_valid,
  input  logic [LS_W-1:0]  hw_ls,
  input  logic [SPD_W-1:0] hw_speed,
  input  logic             hw_reset_done,
  input  logic             hw_cfg_err,
  input  logic             hw_cold_attach,
  output logic             port_reset_out,
  output logic             warm_reset_out,
  output logic [LS_W-1:0]  link_state_out,
  output logic             power_out,
  output logic [1:0]       indicator_out,
  output logic             irq
);
  logic             conn_q, oc_q, pwr_q;
  logic [1:0]       ind_q;
  logic [LS_W-1:0]  ls_q;
  logic [SPD_W-1:0] speed_q;
  logic             prst_q, warm_q, en_q, cas_q;
  logic             rc_set, wrc_set, pec_set, plc_set;
  logic [N_CHG-1:0] chg_set, chg_clr, chg_q;
  logic             unused_wr;

  assign unused_wr = ^{wr_data[30:24], wr_data[13:10], wr_data[3:2], wr_data[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
      pwr_q  <= 1'b1;
      ind_q  <= '0;
    end else begin
      conn_q <= hw_connect;
      oc_q   <= hw_overcur;
      if (wr_en) begin
        pwr_q <= wr_data[B_PWR];
        ind_q <= wr_data[B_IND_LO +: 2];
      end
    end
  end

  psc_link_track u_link (
    .clk      (clk),
    .rst      (rst),
    .hw_valid (hw_ls_valid),
    .hw_ls    (hw_ls),
    .sw_wr    (wr_en && wr_data[B_STROBE]),
    .sw_ls    (wr_data[B_LS_LO +: LS_W]),
    .ls_q     (ls_q),
    .plc_set  (plc_set)
  );

  psc_reset_ctl u_rst (
    .clk         (clk),
    .rst         (rst),
    .conn_q      (conn_q),
    .conn_in     (hw_connect),
    .oc_q        (oc_q),
    .oc_in       (hw_overcur),
    .start       (wr_en && (wr_data[B_PRST] || wr_data[B_WARM])),
    .start_warm  (wr_data[B_WARM]),
    .sw_disable  (wr_en && wr_data[B_EN]),
    .done        (hw_reset_done),
    .speed_in    (hw_speed),
    .cold_attach (hw_cold_attach),
    .prst_q      (prst_q),
    .warm_q      (warm_q),
    .en_q        (en_q),
    .speed_q     (speed_q),
    .cas_q       (cas_q),
    .rc_set      (rc_set),
    .wrc_set     (wrc_set),
    .pec_set     (pec_set)
  );

  always_comb begin
    chg_set        = '0;
    chg_set[C_CSC] = hw_connect != conn_q;
    chg_set[C_PEC] = pec_set;
    chg_set[C_WRC] = wrc_set;
    chg_set[C_OCC] = hw_overcur != oc_q;
    chg_set[C_RC]  = rc_set;
    chg_set[C_PLC] = plc_set;
    chg_set[C_CEC] = hw_cfg_err;
  end

  assign chg_clr = wr_en ? wr_data[B_CHG_LO +: N_CHG] : '0;

  psc_change_flags #(.N(N_CHG)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .flag_q (chg_q)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[B_CONN]              = conn_q;
    rd_data[B_EN]                = en_q;
    rd_data[B_OC]                = oc_q;
    rd_data[B_PRST]              = prst_q;
    rd_data[B_LS_LO +: LS_W]     = ls_q;
    rd_data[B_PWR]               = pwr_q;
    rd_data[B_SPD_LO +: SPD_W]   = speed_q;
    rd_data[B_IND_LO +: 2]       = ind_q;
    rd_data[B_CHG_LO +: N_CHG]   = chg_q;
    rd_data[B_CAS]               = cas_q;
  end

  assign port_reset_out = prst_q;
  assign warm_reset_out = prst_q && warm_q;
  assign link_state_out = ls_q;
  assign power_out      = pwr_q;
  assign indicator_out  = ind_q;
  assign irq            = |chg_q;
endmodule

// File: rtl/psc_port_reg_chk.sv
module psc_port_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        hw_connect,
  input logic        hw_ls_valid,
  input logic        hw_reset_done,
  input logic        hw_cfg_err,
  input logic        hw_cold_attach,
  input logic        warm_reset_out,
  input logic        irq
);
  p_rsv_zero_r12: assert property (@(posedge clk) disable iff (rst)
    rd_data[2] == 1'b0 && rd_data[30:25] == 6'd0 && rd_data[16] == 1'b0);

  p_csc_r2: assert property (@(posedge clk) disable iff (rst)
    (hw_connect != rd_data[0]) |=> rd_data[17]);

  p_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[16] && !hw_ls_valid) |=> $stable(rd_data[8:5]));

  p_rc_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_data[4]) |-> rd_data[21]);

  p_warm_done_r7: assert property (@(posedge clk) disable iff (rst)
    (warm_reset_out && hw_reset_done && !hw_cold_attach) |=> (rd_data[19] && !rd_data[24]));

  p_cec_r9: assert property (@(posedge clk) disable iff (rst)
    hw_cfg_err |=> rd_data[23]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && irq) |=> irq);
endmodule

bind psc_port_reg psc_port_reg_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .hw_connect     (hw_connect),
  .hw_ls_valid    (hw_ls_valid),
  .hw_reset_done  (hw_reset_done),
  .hw_cfg_err     (hw_cfg_err),
  .hw_cold_attach (hw_cold_attach),
  .warm_reset_out (warm_reset_out),
  .irq            (irq)
);

// File: tb/test_psc_port_reg.sv
`timescale 1ns/1ps
module test_psc_port_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hw_connect = 1'b0, hw_overcur = 1'b0, hw_ls_valid = 1'b0;
  logic [3:0]  hw_ls = '0, hw_speed = '0;
  logic        hw_reset_done = 1'b0, hw_cfg_err = 1'b0, hw_cold_attach = 1'b0;
  logic        port_reset_out, warm_reset_out, power_out, irq;
  logic [3:0]  link_state_out;
  logic [1:0]  indicator_out;

  int n_chk = 0, n_bad = 0;
  bit done_run = 0;

  // reference model state
  logic m_conn, m_oc, m_en, m_rst, m_warm, m_pwr, m_cas;
  logic [3:0] m_ls, m_prev, m_spd;
  logic [1:0] m_ind;
  logic [6:0] m_flags;

  always #2.5 clk = ~clk;

  psc_port_reg i_psc_port_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hw_connect(hw_connect), .hw_overcur(hw_overcur), .hw_ls_valid(hw_ls_valid),
    .hw_ls(hw_ls), .hw_speed(hw_speed), .hw_reset_done(hw_reset_done),
    .hw_cfg_err(hw_cfg_err), .hw_cold_attach(hw_cold_attach),
    .port_reset_out(port_reset_out), .warm_reset_out(warm_reset_out),
    .link_state_out(link_state_out), .power_out(power_out),
    .indicator_out(indicator_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic plc_rule(input logic [3:0] pp, input logic [3:0] o, input logic [3:0] n);
    return (n == 4'd6) || (o == 4'd3 && n == 4'd15) || (o == 4'd15 && n == 4'd0) ||
           (o == 4'd8 && n == 4'd0 && (pp == 4'd15 || pp == 4'd3)) ||
           (o == 4'd3 && n == 4'd0) || (o == 4'd2 && n == 4'd0) ||
           (o == 4'd0 && n == 4'd4);
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r;
    r = '0;
    r[0] = m_conn; r[1] = m_en; r[3] = m_oc; r[4] = m_rst; r[8:5] = m_ls;
    r[9] = m_pwr; r[13:10] = m_spd; r[15:14] = m_ind; r[23:17] = m_flags; r[24] = m_cas;
    return r;
  endfunction

  task automatic model_reset();
    m_conn = 0; m_oc = 0; m_en = 0; m_rst = 0; m_warm = 0; m_pwr = 1; m_cas = 0;
    m_ls = 0; m_prev = 0; m_spd = 0; m_ind = 0; m_flags = 0;
  endtask

  task automatic model_step();
    logic cmp, beg, drop, pec, plc, unplug;
    logic [6:0] sets, clrs;
    cmp    = hw_reset_done && m_rst;
    beg    = !cmp && wr_en && (wr_data[4] || wr_data[31]) && !m_rst;
    unplug = m_conn && !hw_connect;
    drop   = m_en && (unplug || (!m_oc && hw_overcur));
    pec    = drop && !cmp && !beg;
    plc    = 0;
    sets   = {hw_cfg_err, 1'b0, cmp, hw_overcur != m_oc, cmp && m_warm, pec, hw_connect != m_conn};
    if (hw_ls_valid && hw_ls != m_ls) begin
      plc = plc_rule(m_prev, m_ls, hw_ls); m_prev = m_ls; m_ls = hw_ls;
    end else if (!hw_ls_valid && wr_en && wr_data[16] && wr_data[8:5] != m_ls) begin
      m_prev = m_ls; m_ls = wr_data[8:5];
    end
    sets[5] = plc;
    if (hw_cold_attach) m_cas = 1; else if (cmp && m_warm) m_cas = 0;
    if (cmp) begin
      m_rst = 0; m_warm = 0; m_en = hw_connect; m_spd = hw_connect ? hw_speed : 4'd0;
    end else begin
      if (beg) begin m_rst = 1; m_warm = wr_data[31]; m_en = 0; end
      else if (drop || (wr_en && wr_data[1])) m_en = 0;
      if (unplug) m_spd = 0;
    end
    if (wr_en) begin m_pwr = wr_data[9]; m_ind = wr_data[15:14]; end
    clrs = wr_en ? wr_data[23:17] : 7'd0;
    m_flags = (m_flags & ~clrs) | sets;
    m_conn = hw_connect; m_oc = hw_overcur;
  endtask

  task automatic compare_all();
    logic [31:0] e;
    e = exp_rd();
    check("R2 connect/overcurrent", {30'd0, rd_data[3], rd_data[0]}, {30'd0, e[3], e[0]});
    check("R3 R4 link state", rd_data[8:5], e[8:5]);
    check("R5 R8 reset/enable", rd_data[4:1], e[4:1]);
    check("R6 speed", rd_data[13:10], e[13:10]);
    check("R7 cold attach", rd_data[24], e[24]);
    check("R2 connect change", rd_data[17], e[17]);
    check("R8 enable change", rd_data[18], e[18]);
    check("R7 warm change", rd_data[19], e[19]);
    check("R2 overcurrent change", rd_data[20], e[20]);
    check("R5 reset change", rd_data[21], e[21]);
    check("R4 link change", rd_data[22], e[22]);
    check("R9 R10 config change", rd_data[23], e[23]);
    check("R12 power/indicator", {rd_data[15:14], rd_data[9], power_out, indicator_out},
          {e[15:14], e[9], e[9], e[15:14]});
    check("R12 reserved", {rd_data[31:25], rd_data[16], rd_data[2]}, 9'd0);
    check("R11 irq", irq, |e[23:17]);
    check("R7 reset outputs", {port_reset_out, warm_reset_out, link_state_out},
          {m_rst, m_rst && m_warm, m_ls});
  endtask

  // inputs set at negedge; one clock; model; compare at next negedge
  task automatic cycle();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; hw_ls_valid = 0; hw_reset_done = 0; hw_cfg_err = 0; hw_cold_attach = 0;
  endtask

  task automatic sw_write(input logic [31:0] d);
    wr_en = 1; wr_data = d; cycle();
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 reset value", rd_data, 32'h0000_0200);
    check("R1 irq low", irq, 1'b0);
    check("R1 power out", power_out, 1'b1);

    // R3: link state bits without strobe are ignored
    sw_write(32'h0000_0300 | (32'd15 << 5));
    check("R3 no-strobe write ignored", rd_data[8:5], 4'd0);
    sw_write(32'h0001_0200 | (32'd3 << 5));
    check("R3 strobe write U3", rd_data[8:5], 4'd3);
    check("R3 strobe reads zero", rd_data[16], 1'b0);

    // R4: U3 -> Resume -> Recovery -> U0 flags twice, not on Resume->Recovery
    hw_ls_valid = 1; hw_ls = 4'd15; cycle();
    check("R4 U3 to Resume sets flag", rd_data[22], 1'b1);
    sw_write(32'h0040_0200);
    check("R10 write one clears", rd_data[22], 1'b0);
    hw_ls_valid = 1; hw_ls = 4'd8; cycle();
    check("R4 Resume to Recovery no flag", rd_data[22], 1'b0);
    hw_ls_valid = 1; hw_ls = 4'd0; cycle();
    check("R4 Recovery to U0 after Resume", rd_data[22], 1'b1);
    sw_write(32'h0040_0200);
    hw_ls_valid = 1; hw_ls = 4'd7; cycle();
    hw_ls_valid = 1; hw_ls = 4'd8; cycle();
    hw_ls_valid = 1; hw_ls = 4'd0; cycle();
    check("R4 Recovery to U0 after Polling no flag", rd_data[22], 1'b0);

    // R10: hardware set wins against same-cycle clear
    hw_cfg_err = 1; wr_en = 1; wr_data = 32'h0080_0200; cycle();
    check("R10 set beats clear", rd_data[23], 1'b1);
    sw_write(32'h0000_0200);
    check("R10 write zero keeps flag", rd_data[23], 1'b1);

    // R5 R6 R7: warm reset with connection and cold attach
    hw_connect = 1; hw_cold_attach = 1; cycle();
    sw_write(32'h8000_0200);
    check("R7 warm output", warm_reset_out, 1'b1);
    check("R6 speed zero before completion", rd_data[13:10], 4'd0);
    hw_speed = 4'd5; hw_reset_done = 1; cycle();
    check("R5 reset cleared", rd_data[4], 1'b0);
    check("R6 speed latched", rd_data[13:10], 4'd5);
    check("R7 cold attach cleared", rd_data[24], 1'b0);
    check("R7 warm change set", rd_data[19], 1'b1);
    snap = rd_data;
    sw_write(32'h0000_3C09 & ~32'h0000_0200);
    check("R2 software cannot move connect/speed", {rd_data[13:10], rd_data[0]}, {snap[13:10], snap[0]});
    check("R12 power off", power_out, 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      wr_en          = ($urandom % 4) == 0;
      wr_data        = $urandom;
      if (($urandom % 8) != 0) wr_data[4] = 0;
      if (($urandom % 8) != 0) wr_data[31] = 0;
      if (($urandom % 16) == 0) hw_connect = ~hw_connect;
      if (($urandom % 32) == 0) hw_overcur = ~hw_overcur;
      hw_ls_valid    = ($urandom % 4) == 0;
      case ($urandom % 6)
        0: hw_ls = 4'd0; 1: hw_ls = 4'd3; 2: hw_ls = 4'd15;
        3: hw_ls = 4'd8; 4: hw_ls = 4'd2; default: hw_ls = 4'($urandom);
      endcase
      hw_speed       = 4'($urandom % 6);
      hw_reset_done  = ($urandom % 8) == 0;
      hw_cfg_err     = ($urandom % 32) == 0;
      hw_cold_attach = ($urandom % 32) == 0;
      cycle();
    end

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule